// File: doc/BRIEF.md
# Tile Background Fetch and Layer Mixer

This block builds one display line of a tiled background and merges it with a sprite line buffer that is already filled. When a line starts it walks across the line in eight-pixel columns. For each column it reads a 16-bit name-table entry and then the four planar bytes of the tile row that entry selects. It applies flips, palette selection and priority to the decoded row. It then produces one 5-bit colour index per pixel, 256 pixels per line.

Vertical scroll wraps at 224 rows. A lock option keeps the right-hand columns from scrolling vertically. A second lock option stops horizontal scroll on the top lines. Horizontal scroll has a coarse part that moves the name-table column and a fine part that shifts pixels. A per-tile priority flag lets an opaque background pixel hide a sprite. The column schedule leaves one shared memory slot per column for outside accesses. That slot is given up to refresh every eighth column. Turning colour indices into RGB and building the sprite line buffer are done elsewhere.

Top module: `bgtile_mixer`

## Requirements
- R1: After reset, `pix_valid`, `vram_rd` and `ext_grant` are low and the block is idle until `line_start`.
- R2: A `line_start` pulse seen while idle starts a line. A line runs for 272 cycles, counted from the cycle after the pulse as cycle 0. `pix_valid` is high on exactly 256 consecutive cycles, from cycle 17 to cycle 272, one pixel per cycle from left to right. A `line_start` pulse that arrives while a line is running is ignored.
- R3: The line has 33 fetch periods (f = 0..32) of 8 cycles each. In phases 0 and 1 the block reads the entry low byte and then the high byte. Phase 2 makes no read. In phases 3..6 it reads planes 0..3 at tile×32 + tilerow×4 + plane. Read data is taken one cycle after the read. In a plane byte, bit 7 is the leftmost pixel, and plane p gives bit p of the 4-bit pixel value.
- R4: The entry address is base×2048 + (row/8)×64 + ((f + hscroll/8) mod 32)×2, where base is the 3-bit `nt_base`.
- R5: The effective row is line + vscroll. If that value is above 223, 224 is subtracted from it. When `vscroll_lock` is set, fetch periods 24 and above use the line alone.
- R6: Horizontal scroll is latched at line start. It is forced to 0 when `hscroll_lock` is set and the line is below 16. Pixel k of output column j shows background pixel (j×8 + k + hscroll) mod 256.
- R7: In an entry, bits 8:0 select the tile. Bit 9 mirrors the row horizontally. Bit 10 mirrors it vertically, using tile row 7 − (row mod 8). Bit 11 sets bit 4 of the background colour index. Bit 12 is background priority.
- R8: Mix order: an opaque background pixel with priority wins. Otherwise a non-zero sprite value s gives 16 + s. Otherwise an opaque background pixel is shown. Otherwise the backdrop 16 + `backdrop` is shown.
- R9: A background pixel is transparent when its 4-bit value is 0, whatever its palette bit.
- R10: When `col0_mask` is set, all 8 pixels of output column 0 show the backdrop.
- R11: Pixel x reads sprite buffer address x. When `spr_shift` is set it reads x + 8 instead.
- R12: `ext_grant` is high in phase 2 of periods 0..31, except in periods 6, 14, 22 and 30, which go to refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Starts a line when idle |
| line_idx | input | 8 | Line number, latched at start |
| vscroll | input | 8 | Vertical scroll |
| hscroll | input | 8 | Horizontal scroll, latched at start |
| nt_base | input | 3 | Name-table base (address bits 13:11) |
| backdrop | input | 4 | Backdrop colour, low 4 bits |
| vscroll_lock | input | 1 | Periods 24+ ignore vertical scroll |
| hscroll_lock | input | 1 | Lines below 16 ignore horizontal scroll |
| col0_mask | input | 1 | Column 0 shows the backdrop |
| spr_shift | input | 1 | Sprite buffer read 8 positions further on |
| vram_rd | output | 1 | Video memory read strobe |
| vram_addr | output | 14 | Video memory byte address |
| vram_data | input | 8 | Read data, one cycle after the strobe |
| spr_addr | output | 9 | Sprite line-buffer address |
| spr_data | input | 4 | Sprite pixel, combinational read |
| ext_grant | output | 1 | Shared slot free for outside access |
| pix_valid | output | 1 | Pixel colour valid |
| pix_color | output | 5 | Pixel colour index |

## Verification
The bench compares every read address, every grant cycle and every pixel with a behavioural model of the line. It fills memory with hashed contents, so random entries cover all combinations of flip, palette and priority, with transparent pixels mixed in. Lines with coarse-only scroll and with fine scroll show whether the entry column and the pixel shift are each handled correctly. A row sum above 223 shows whether the wrap is applied. The lock modes show which columns and lines lose their scroll. A hand-built entry, with a priority tile over a transparent half and a sprite under it, shows whether the mix order is correct. The column-0 mask and the sprite shift are each run on their own, so an error in one cannot hide an error in the other.

// File: rtl/bgtile_pkg.sv
package bgtile_pkg;

  localparam int ADDR_W = 14;

  typedef logic [7:0][3:0] pix_row_t;

  typedef struct packed {
    logic     pri;
    logic     pal;
    pix_row_t px;
  } tile_row_t;

  // wrapped row: line plus optional scroll, folded once at the wrap height
  function automatic logic [7:0] eff_row(input logic [7:0] line, input logic [7:0] vs,
                                         input logic use_vs, input int unsigned wrap);
    logic [8:0] s;
    s = {1'b0, line} + (use_vs ? {1'b0, vs} : 9'd0);
    if (s >= 9'(wrap)) s = s - 9'(wrap);
    return s[7:0];
  endfunction

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [2:0] base,
                                                   input logic [7:0] row,
                                                   input logic [4:0] tcol);
    return {base, 11'd0} + {3'd0, row[7:3], 6'd0} + {8'd0, tcol, 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] pattern_addr(input logic [8:0] tile,
                                                     input logic [2:0] trow,
                                                     input logic [1:0] plane);
    return {tile, trow, plane};
  endfunction

  // planar bytes to eight 4-bit pixels, index 0 = leftmost on screen
  function automatic pix_row_t decode_row(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [7:0] b2, input logic [7:0] b3,
                                          input logic hflip);
    pix_row_t r;
    int s;
    for (int q = 0; q < 8; q++) begin
      s = hflip ? q : 7 - q;
      r[q] = {b3[s], b2[s], b1[s], b0[s]};
    end
    return r;
  endfunction

  function automatic logic [4:0] mix_px(input logic [3:0] bg, input logic pal, input logic pri,
                                        input logic [3:0] spr, input logic [3:0] bd,
                                        input logic blank);
    if (blank)               return {1'b1, bd};
    if (pri && bg != 4'd0)   return {pal, bg};
    if (spr != 4'd0)         return {1'b1, spr};
    if (bg != 4'd0)          return {pal, bg};
    return {1'b1, bd};
  endfunction

endpackage

// File: rtl/bgtile_seq.sv
module bgtile_seq #(
  parameter int COLS      = 32,
  parameter int REF_EVERY = 8,
  parameter int REF_AT    = 6,
  localparam int PERIODS  = COLS + 2,
  localparam int CW       = $clog2(PERIODS * 8),
  localparam int PW       = CW - 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  output logic          busy,
  output logic [PW-1:0] period,
  output logic [2:0]    phase,
  output logic          start_acc,
  output logic          ext_grant
);
  localparam int LAST = PERIODS * 8 - 1;

  logic [CW-1:0] cnt;

  assign start_acc = !busy && line_start;
  assign period    = cnt[CW-1:3];
  assign phase     = cnt[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (line_start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == CW'(LAST)) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ext_grant = busy && (period < PW'(COLS)) && (phase == 3'd2) &&
                     ((int'(period) % REF_EVERY) != REF_AT);

  // R12
  refresh_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == 3'd2 && (int'(period) % REF_EVERY) == REF_AT) |-> !ext_grant);

  // R2
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CW'(LAST)) |=> (busy && cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/bgtile_fetch.sv
module bgtile_fetch
  import bgtile_pkg::*;
#(
  parameter int COLS       = 32,
  parameter int VLOCK_FROM = 24,
  parameter int WRAP       = 224,
  parameter int PW         = 6,
  localparam int CB        = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [PW-1:0]     period,
  input  logic [2:0]        phase,
  input  logic [7:0]        line_q,
  input  logic [7:0]        hs_q,
  input  logic [7:0]        vscroll,
  input  logic              vscroll_lock,
  input  logic [2:0]        nt_base,
  input  logic [7:0]        vram_data,
  output logic              vram_rd,
  output logic [ADDR_W-1:0] vram_addr,
  output logic              tile_done,
  output tile_row_t         tile_row
);
  logic        fetch_en, use_vs;
  logic [7:0]  row;
  logic [CB-1:0] tcol;
  logic [7:0]  ent_lo, ent_hi, pl0, pl1, pl2;
  logic [15:0] ent;
  logic [2:0]  trow;
  logic [ADDR_W-1:0] ea;

  assign fetch_en = busy && (period <= PW'(COLS));
  assign use_vs   = !(vscroll_lock && period >= PW'(VLOCK_FROM));
  assign row      = eff_row(line_q, vscroll, use_vs, WRAP);
  assign tcol     = CB'(period) + CB'(hs_q >> 3);
  assign ea       = entry_addr(nt_base, row, 5'(tcol));
  assign ent      = {ent_hi, ent_lo};
  assign trow     = ent[10] ? ~row[2:0] : row[2:0];

  always_comb begin
    vram_rd   = 1'b0;
    vram_addr = ea;
    case (phase)
      3'd0: vram_rd = fetch_en;
      3'd1: begin vram_rd = fetch_en; vram_addr = ea + 1'b1; end
      3'd3, 3'd4, 3'd5, 3'd6: begin
        vram_rd   = fetch_en;
        vram_addr = pattern_addr(ent[8:0], trow, 2'(phase - 3'd3));
      end
      default: vram_rd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_lo <= '0; ent_hi <= '0; pl0 <= '0; pl1 <= '0; pl2 <= '0;
    end else if (fetch_en) begin
      case (phase)
        3'd1: ent_lo <= vram_data;
        3'd2: ent_hi <= vram_data;
        3'd4: pl0    <= vram_data;
        3'd5: pl1    <= vram_data;
        3'd6: pl2    <= vram_data;
        default: ;
      endcase
    end
  end

  assign tile_done = fetch_en && (phase == 3'd7);
  assign tile_row  = {ent[12], ent[11], decode_row(pl0, pl1, pl2, vram_data, ent[9])};

  // R3
  slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2 || phase == 3'd7) |-> !vram_rd);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |-> busy);

endmodule

// File: rtl/bgtile_mix.sv
module bgtile_mix
  import bgtile_pkg::*;
#(
  parameter int COLS = 32,
  parameter int PW   = 6,
  localparam int CB  = $clog2(COLS),
  localparam int XW  = CB + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [PW-1:0] period,
  input  logic [2:0]    phase,
  input  logic          tile_done,
  input  tile_row_t     tile_row,
  input  logic [2:0]    hs_fine,
  input  logic          col0_mask,
  input  logic          spr_shift,
  input  logic [3:0]    backdrop,
  input  logic [3:0]    spr_data,
  output logic [XW-1:0] spr_addr,
  output logic          pix_valid,
  output logic [4:0]    pix_color
);
  tile_row_t older, newer, src;
  logic          out_en, blank, col0_q;
  logic [CB-1:0] col;
  logic [3:0]    sel;
  logic [3:0]    bgc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older <= '0;
      newer <= '0;
    end else if (tile_done) begin
      older <= newer;
      newer <= tile_row;
    end
  end

  assign out_en   = busy && (period >= PW'(2));
  assign col      = CB'(period - PW'(2));
  assign sel      = {1'b0, phase} + {1'b0, hs_fine};
  assign src      = sel[3] ? newer : older;
  assign bgc      = src.px[sel[2:0]];
  assign spr_addr = {1'b0, col, phase} + (spr_shift ? XW'(8) : XW'(0));
  assign blank    = col0_mask && (col == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_color <= '0;
      col0_q    <= 1'b0;
    end else begin
      pix_valid <= out_en;
      col0_q    <= out_en && (col == '0);
      if (out_en) pix_color <= mix_px(bgc, src.pal, src.pri, spr_data, backdrop, blank);
    end
  end

  // R10
  col0_backdrop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && col0_q && col0_mask) |-> (pix_color == {1'b1, backdrop}));

  // R2
  line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_valid) |-> !$past(busy));

endmodule

// File: rtl/bgtile_mixer.sv
module bgtile_mixer
  import bgtile_pkg::*;
#(
  parameter int COLS        = 32,
  parameter int HLOCK_LINES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  input  logic [7:0]  line_idx,
  input  logic [7:0]  vscroll,
  input  logic [7:0]  hscroll,
  input  logic [2:0]  nt_base,
  input  logic [3:0]  backdrop,
  input  logic        vscroll_lock,
  input  logic        hscroll_lock,
  input  logic        col0_mask,
  input  logic        spr_shift,
  output logic        vram_rd,
  output logic [13:0] vram_addr,
  input  logic [7:0]  vram_data,
  output logic [8:0]  spr_addr,
  input  logic [3:0]  spr_data,
  output logic        ext_grant,
  output logic        pix_valid,
  output logic [4:0]  pix_color
);
  localparam int PW = $clog2((COLS + 2) * 8) - 3;

  logic          busy, start_acc, tile_done;
  logic [PW-1:0] period;
  logic [2:0]    phase;
  logic [7:0]    line_q, hs_q;
  tile_row_t     tile_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      hs_q   <= '0;
    end else if (start_acc) begin
      line_q <= line_idx;
      hs_q   <= (hscroll_lock && line_idx < 8'(HLOCK_LINES)) ? 8'd0 : hscroll;
    end
  end

  bgtile_seq #(.COLS(COLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .busy(busy),
    .period(period), .phase(phase), .start_acc(start_acc), .ext_grant(ext_grant));

  bgtile_fetch #(.COLS(COLS), .PW(PW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .busy(busy), .period(period), .phase(phase),
    .line_q(line_q), .hs_q(hs_q), .vscroll(vscroll), .vscroll_lock(vscroll_lock),
    .nt_base(nt_base), .vram_data(vram_data), .vram_rd(vram_rd), .vram_addr(vram_addr),
    .tile_done(tile_done), .tile_row(tile_row));

  bgtile_mix #(.COLS(COLS), .PW(PW)) u_mix (
    .clk(clk), .rst_n(rst_n), .busy(busy), .period(period), .phase(phase),
    .tile_done(tile_done), .tile_row(tile_row), .hs_fine(hs_q[2:0]),
    .col0_mask(col0_mask), .spr_shift(spr_shift), .backdrop(backdrop),
    .spr_data(spr_data), .spr_addr(spr_addr), .pix_valid(pix_valid), .pix_color(pix_color));

endmodule

// File: tb/bgtile_mixer_tb.sv
module bgtile_mixer_tb;
  logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0;
  logic [7:0] line_idx = '0, vscroll = '0, hscroll = '0;
  logic [2:0] nt_base = '0;
  logic [3:0] backdrop = '0;
  logic vscroll_lock = 0, hscroll_lock = 0, col0_mask = 0, spr_shift = 0;
  logic vram_rd, ext_grant, pix_valid;
  logic [13:0] vram_addr;
  logic [7:0] vram_data = '0;
  logic [8:0] spr_addr;
  logic [3:0] spr_data;
  logic [4:0] pix_color;

  int checks = 0, errors = 0, salt = 1, ssalt = 3;
  bit done = 0;
  logic [7:0] ovr [int];

  int exp_rd [0:272];
  int exp_addr [0:272];
  int exp_grant [0:272];
  int exp_pix [0:255];
  int tcolr [0:32][0:7];
  int tpal [0:32];
  int tpri [0:32];

  always #4 clk = ~clk;

  bgtile_mixer u_dut (.*);

  function automatic logic [7:0] vmem(input int a);
    if (ovr.exists(a)) return ovr[a];
    return 8'((a * 113) ^ ((a >> 4) * 29) ^ (salt * 71));
  endfunction

  function automatic logic [3:0] spr_fn(input int a);
    if (((a * 29 + ssalt * 7) % 11) < 5) return 4'(a * 5 + ssalt);
    return 4'd0;
  endfunction

  assign spr_data = spr_fn(int'(spr_addr));

  always @(posedge clk) if (vram_rd) vram_data <= vmem(int'(vram_addr));

  task automatic check(input bit ok, input string req, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic build_model();
    int hs, r, tc, ea, ent, fr, pa, srcb, c, f, q, s;
    int b [4];
    hs = (hscroll_lock && line_idx < 16) ? 0 : int'(hscroll);
    for (int n = 0; n <= 272; n++) begin exp_rd[n] = 0; exp_addr[n] = 0; exp_grant[n] = 0; end
    for (int fi = 0; fi <= 32; fi++) begin
      r = int'(line_idx) + ((vscroll_lock && fi >= 24) ? 0 : int'(vscroll));
      if (r > 223) r = r - 224;
      tc = (fi + (hs / 8)) % 32;
      ea = int'(nt_base) * 2048 + (r / 8) * 64 + tc * 2;
      ent = int'(vmem(ea)) + 256 * int'(vmem(ea + 1));
      fr = ((ent >> 10) & 1) ? 7 - (r % 8) : r % 8;
      pa = (ent & 511) * 32 + fr * 4;
      for (int p = 0; p < 4; p++) begin
        b[p] = int'(vmem(pa + p));
        exp_rd[fi * 8 + 3 + p] = 1; exp_addr[fi * 8 + 3 + p] = pa + p;
      end
      exp_rd[fi * 8] = 1; exp_addr[fi * 8] = ea;
      exp_rd[fi * 8 + 1] = 1; exp_addr[fi * 8 + 1] = ea + 1;
      for (int qq = 0; qq < 8; qq++) begin
        srcb = ((ent >> 9) & 1) ? qq : 7 - qq;
        c = 0;
        for (int p = 0; p < 4; p++) c = c | (((b[p] >> srcb) & 1) << p);
        tcolr[fi][qq] = c;
      end
      tpal[fi] = (ent >> 11) & 1;
      tpri[fi] = (ent >> 12) & 1;
    end
    for (int cc = 0; cc < 32; cc++) if (cc % 8 != 6) exp_grant[cc * 8 + 2] = 1;
    for (int x = 0; x < 256; x++) begin
      f = x / 8 + ((x % 8 + hs % 8) / 8);
      q = (x % 8 + hs % 8) % 8;
      c = tcolr[f][q];
      s = int'(spr_fn(x + (spr_shift ? 8 : 0)));
      if (col0_mask && x < 8)        exp_pix[x] = 16 + int'(backdrop);
      else if (tpri[f] == 1 && c != 0) exp_pix[x] = tpal[f] * 16 + c;
      else if (s != 0)               exp_pix[x] = 16 + s;
      else if (c != 0)               exp_pix[x] = tpal[f] * 16 + c;
      else                           exp_pix[x] = 16 + int'(backdrop);
    end
  endtask

  task automatic run_line(input string tag);
    build_model();
    @(negedge clk) line_start = 1;
    @(negedge clk) line_start = 0;
    for (int n = 0; n <= 272; n++) begin
      line_start = (n == 100);  // R2: ignored mid-line
      check(int'(vram_rd) == exp_rd[n], "R3", int'(vram_rd), exp_rd[n], $sformatf("%s read strobe cycle %0d", tag, n));
      if (exp_rd[n] == 1)
        check(int'(vram_addr) == exp_addr[n], (n % 8 < 2) ? "R4" : "R3", int'(vram_addr), exp_addr[n],
              $sformatf("%s address cycle %0d", tag, n));
      check(int'(ext_grant) == exp_grant[n], "R12", int'(ext_grant), exp_grant[n], $sformatf("%s grant cycle %0d", tag, n));
      check(int'(pix_valid) == int'(n >= 17), "R2", int'(pix_valid), int'(n >= 17), $sformatf("%s valid cycle %0d", tag, n));
      if (n >= 17)
        check(int'(pix_color) == exp_pix[n - 17], tag, int'(pix_color), exp_pix[n - 17], $sformatf("pixel %0d", n - 17));
      @(negedge clk);
    end
    line_start = 0;
    for (int n = 0; n < 6; n++) begin
      check(!pix_valid && !vram_rd, "R2", int'(pix_valid | vram_rd), 0, "idle after line");
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(!pix_valid && !vram_rd && !ext_grant, "R1", int'(pix_valid | vram_rd | ext_grant), 0, "reset state");
    backdrop = 4'd9;
    // R3 R4 plain line, coarse-only scroll
    nt_base = 3'd3; line_idx = 8'd40; run_line("R3");
    nt_base = 3'd5; line_idx = 8'd100; hscroll = 8'h48; salt = 4; run_line("R4");
    // R5 wrap and lock
    hscroll = 0; line_idx = 8'd150; vscroll = 8'd100; run_line("R5");
    line_idx = 8'd10; vscroll = 8'd37; vscroll_lock = 1; salt = 7; run_line("R5");
    vscroll_lock = 0; vscroll = 0;
    // R6 fine scroll and lock
    hscroll = 8'h2D; line_idx = 8'd50; run_line("R6");
    hscroll_lock = 1; line_idx = 8'd8; run_line("R6");
    line_idx = 8'd20; run_line("R6");
    hscroll_lock = 0; hscroll = 0;
    // R7 R9 random entries under new contents
    salt = 11; ssalt = 5; line_idx = 8'd77; run_line("R7");
    salt = 23; ssalt = 9; line_idx = 8'd130; hscroll = 8'h13; run_line("R9");
    hscroll = 0;
    // R10 R11
    col0_mask = 1; line_idx = 8'd60; run_line("R10");
    col0_mask = 0; spr_shift = 1; run_line("R11");
    spr_shift = 0;
    // R8 directed: priority tile, left half opaque colour 1, right half transparent
    nt_base = 0; line_idx = 0; salt = 2;
    ovr[0] = 8'h01; ovr[1] = 8'h10;
    ovr[32] = 8'hF0; ovr[33] = 8'h00; ovr[34] = 8'h00; ovr[35] = 8'h00;
    run_line("R8");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule